// File: doc/BRIEF.md
# SPI Controller with Mode Fault

A single-byte serial peripheral port that can run as bus master or as a selected slave. Software configures it through a small register bus with three registers: control, status and data. The control register selects enable, bit order, master or slave role, clock polarity and clock phase. It also holds two rate bits that software can read and write but that have no effect, because a fixed divider sets the master clock rate. Writing the data register in master mode sends one byte on MOSI and captures one byte from MISO at the same time. In slave mode the port shifts a byte under an external clock for as long as its select line is held low.

A completion flag in the status register marks the end of each byte. If the interrupt enable bit and a global enable input are both set, the flag also raises an interrupt request. While the port is master and its select line is configured as an input, a low level on that line means another master is driving the bus. In that case the port gives up the master role by clearing its own master bit, and it raises the completion flag so that software is told.

Top module: `spi_port`

## Requirements
- R1: After reset the control register and the status register read 0, SCK is low, the output enables for SCK, MOSI and MISO are 0, and the interrupt request is 0.
- R2: The control register sits at register address 0 and reads back what was written. Its bit fields are: bit 7 interrupt enable, bit 6 port enable, bit 5 bit order, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate (stored only). The status register is at address 1 and carries the completion flag in bit 7. The data register is at address 2.
- R3: With the port enabled in master mode, a write to the data register produces exactly 16 SCK edges, each HALF system clocks apart. Afterwards the received byte can be read from the data register and status bit 7 is 1.
- R4: SCK rests at the clock polarity value when the port is idle. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R5: With bit order 1 the least significant bit is shifted first. With bit order 0 the most significant bit is shifted first. The same order applies to transmission and reception.
- R6: Suppose the port is enabled in master mode, ss_is_out is 0, and ss_i is low. Within 4 clocks, control bit 4 reads 0 and status bit 7 reads 1. When ss_is_out is 1, ss_i has no effect on the master bit.
- R7: The completion flag is cleared by a status read made while the flag is 1, followed by any access to the data register. A data access without that earlier status read leaves the flag set.
- R8: irq is 1 exactly when the completion flag, control bit 7 and gie are all 1.
- R9: While control bit 6 is 0, a data write produces no SCK edges, does not set the flag, and leaves the SCK and MOSI output enables at 0.
- R10: In slave mode, miso_oe is 0 while ss_i is high and 1 while ss_i is low. A high level on ss_i restarts the bit count. A full byte clocked in on sck_i and mosi_i appears in the data register with the flag set. During that byte, MISO shifts out the byte that was last written to the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has side effects on the flag) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| ss_is_out | input | 1 | 1 when the SS pin is configured as an output |
| ss_i | input | 1 | Slave-select pin level |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | MISO output enable |

## Verification
The bench uses the default HALF of 2. This keeps a master byte to about 35 clocks, so every combination of polarity, phase and bit order, with several byte patterns, can be swept in a short run. The master's MISO is looped back inverted from its MOSI. The expected received byte is therefore the complement of the byte sent, and a bench-side monitor rebuilds the transmitted bit order from the sampling edges. The slave sweep drives SCK with a half period of 8 clocks, so the two-stage input synchronisers are exercised at a realistic ratio. It also includes one byte that is cut off by SS to check that the bit count restarts.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       gie,
  output logic       irq,
  input  logic       ss_is_out,
  input  logic       ss_i,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe
);
  localparam int DW = $clog2(HALF) + 1;

  logic [7:0] ctrl, dr, tx, rx;
  logic       spif, armed, busy, sck_r, sck_p;
  logic [3:0] ecnt;
  logic [2:0] bcnt;
  logic [DW-1:0] dcnt;
  logic [1:0] ss_q, sck_q, mosi_q;

  wire en   = ctrl[6];
  wire lsb  = ctrl[5];
  wire mst  = ctrl[4];
  wire cpol = ctrl[3];
  wire cpha = ctrl[2];

  wire ss_s   = ss_q[1];
  wire sck_s  = sck_q[1];
  wire mosi_s = mosi_q[1];

  wire m_ev  = busy && (dcnt == DW'(HALF - 1));
  wire s_ev  = en && !mst && !ss_s && (sck_s != sck_p);
  wire ev    = m_ev || s_ev;
  wire lead  = mst ? !ecnt[0] : (sck_p == cpol);
  wire samp  = ev && (lead != cpha);
  wire setp  = ev && (lead == cpha) && !(cpha && bcnt == 3'd0);
  wire in_bit = mst ? miso_i : mosi_s;
  wire [7:0] rx_nx = lsb ? {in_bit, rx[7:1]} : {rx[6:0], in_bit};

  wire fault  = en && mst && !ss_is_out && !ss_s;
  wire dacc   = (wr_en || rd_en) && sel == 2'd2;
  wire start  = wr_en && sel == 2'd2 && en && mst && !busy && !fault;
  wire done_m = m_ev && ecnt == 4'd15;
  wire done_s = samp && !mst && bcnt == 3'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= 2'b11; sck_q <= 2'b00; mosi_q <= 2'b00; sck_p <= 1'b0;
    end else begin
      ss_q   <= {ss_q[0], ss_i};
      sck_q  <= {sck_q[0], sck_i};
      mosi_q <= {mosi_q[0], mosi_i};
      sck_p  <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; dr <= '0; tx <= '0; rx <= '0;
      spif <= 1'b0; armed <= 1'b0; busy <= 1'b0; sck_r <= 1'b0;
      ecnt <= '0; bcnt <= '0; dcnt <= '0;
    end else begin
      if (wr_en && sel == 2'd0) ctrl <= wdata;
      if (wr_en && sel == 2'd2) begin
        dr <= wdata;
        if (!busy) tx <= wdata;
      end
      if (rd_en && sel == 2'd1 && spif) armed <= 1'b1;
      if (dacc && armed) begin
        spif  <= 1'b0;
        armed <= 1'b0;
      end
      if (start) begin
        busy <= 1'b1; ecnt <= '0; dcnt <= '0; sck_r <= cpol; bcnt <= '0;
      end
      if (busy) begin
        dcnt <= m_ev ? '0 : dcnt + 1'b1;
        if (m_ev) begin
          sck_r <= !sck_r;
          ecnt  <= ecnt + 4'd1;
        end
      end
      if (samp) begin
        rx   <= rx_nx;
        bcnt <= bcnt + 3'd1;
      end
      if (setp) tx <= lsb ? {1'b0, tx[7:1]} : {tx[6:0], 1'b0};
      if (!en || !mst) busy <= 1'b0;
      if (done_m) begin
        busy <= 1'b0;
        dr   <= samp ? rx_nx : rx;
        spif <= 1'b1;
      end
      if (done_s) begin
        dr   <= rx_nx;
        spif <= 1'b1;
      end
      if (!mst && ss_s) bcnt <= '0;
      if (!en) bcnt <= '0;
      if (fault) begin
        ctrl[4] <= 1'b0;
        busy    <= 1'b0;
        spif    <= 1'b1;
        bcnt    <= '0;
      end
    end
  end

  always_comb begin
    case (sel)
      2'd0:    rdata = ctrl;
      2'd1:    rdata = {spif, 7'b0};
      2'd2:    rdata = dr;
      default: rdata = 8'h00;
    endcase
  end

  assign irq     = spif && ctrl[7] && gie;
  assign sck_o   = busy ? sck_r : cpol;
  assign sck_oe  = en && mst;
  assign mosi_oe = en && mst;
  assign mosi_o  = lsb ? tx[0] : tx[7];
  assign miso_o  = lsb ? tx[0] : tx[7];
  assign miso_oe = en && !mst && !ss_s;

  // R6
  mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!ctrl[4] && spif));

  // R9
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  // R10
  ss_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mst && ss_s) |=> bcnt == 3'd0);

  // R3
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_m |=> (spif && !busy));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dacc && !done_m && !done_s && !fault) |=> !spif);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (spif && gie));
endmodule

// File: tb/sim_spi_port.sv
`timescale 1ns/100ps
module sim_spi_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, gie = 1'b0, ss_is_out = 1'b0, ss_i = 1'b1;
  logic sck_i = 1'b0, mosi_i = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;

  always #2.5 clk = ~clk;
  assign miso_i = ~mosi_o;

  spi_port #(.HALF(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .gie(gie), .irq(irq), .ss_is_out(ss_is_out),
    .ss_i(ss_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe));

  int checks = 0, errors = 0, edges = 0;
  logic b_cpol = 1'b0, b_cpha = 1'b0, sck_last = 1'b0, done = 1'b0;
  logic [7:0] cap = '0;
  logic [7:0] pats [3] = '{8'h1E, 8'h80, 8'hC5};

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clr_mon();
    #2; edges = 0; cap = '0;
  endtask

  always @(negedge clk) begin
    if (sck_o != sck_last) begin
      edges++;
      if ((sck_last == b_cpol) != b_cpha) cap = {cap[6:0], mosi_o};
    end
    sck_last = sck_o;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 status", v, 0);
    chk(sck_o == 1'b0 && sck_oe == 1'b0 && mosi_oe == 1'b0 && miso_oe == 1'b0 && irq == 1'b0,
        "R1 pins", {sck_o, sck_oe, mosi_oe, miso_oe, irq}, 0);

    // R2 control read/write
    ss_is_out = 1'b1;
    wr(2'd0, 8'h5A); rd(2'd0, v); chk(v == 8'h5A, "R2 readback", v, 8'h5A);
    wr(2'd0, 8'hA3); rd(2'd0, v); chk(v == 8'hA3, "R2 readback", v, 8'hA3);
    wr(2'd0, 8'h00); rd(2'd0, v); chk(v == 8'h00, "R2 readback", v, 0);
    ss_is_out = 1'b0;

    // R3 R4 R5 master sweep
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++)
        for (int k = 0; k < 3; k++) begin
          b_cpol = m[1]; b_cpha = m[0];
          wr(2'd0, {1'b0, 1'b1, o[0], 1'b1, b_cpol, b_cpha, 2'b01});
          clr_mon();
          wr(2'd2, pats[k]);
          repeat (40) @(negedge clk);
          chk(edges == 16, "R3 edge count", edges, 16);
          chk(sck_o == b_cpol, "R4 idle level", sck_o, b_cpol);
          chk(cap == (o[0] ? rev8(pats[k]) : pats[k]), "R5 tx order", cap,
              o[0] ? rev8(pats[k]) : pats[k]);
          rd(2'd1, v); chk(v == 8'h80, "R3 flag", v, 8'h80);
          rd(2'd2, v); chk(v == ~pats[k], "R4 R5 rx byte", v, ~pats[k]);
          rd(2'd1, v); chk(v == 8'h00, "R7 cleared", v, 0);
        end

    // R7 data access without a preceding status read keeps the flag
    wr(2'd0, 8'h50); clr_mon();
    wr(2'd2, 8'h33); repeat (40) @(negedge clk);
    rd(2'd2, v); rd(2'd1, v); chk(v == 8'h80, "R7 kept", v, 8'h80);
    rd(2'd2, v); rd(2'd1, v); chk(v == 8'h00, "R7 cleared", v, 0);

    // R8 interrupt gating
    wr(2'd0, 8'hD0); wr(2'd2, 8'h11); repeat (40) @(negedge clk);
    gie = 1'b0; #1 chk(irq == 1'b0, "R8 gie off", irq, 0);
    gie = 1'b1; #1 chk(irq == 1'b1, "R8 all set", irq, 1);
    wr(2'd0, 8'h50); #1 chk(irq == 1'b0, "R8 ie off", irq, 0);
    wr(2'd0, 8'hD0);
    rd(2'd1, v); rd(2'd2, v); #1 chk(irq == 1'b0, "R8 flag off", irq, 0);
    gie = 1'b0;

    // R9 disabled port
    wr(2'd0, 8'h10); clr_mon();
    wr(2'd2, 8'h77); repeat (40) @(negedge clk);
    chk(edges == 0, "R9 no edges", edges, 0);
    chk(sck_oe == 1'b0 && mosi_oe == 1'b0, "R9 oe", {sck_oe, mosi_oe}, 0);
    rd(2'd1, v); chk(v == 8'h00, "R9 no flag", v, 0);

    // R6 mode fault
    wr(2'd0, 8'h50); ss_i = 1'b0; repeat (4) @(negedge clk);
    rd(2'd0, v); chk(v[4] == 1'b0, "R6 master cleared", v, 8'h40);
    rd(2'd1, v); chk(v == 8'h80, "R6 flag", v, 8'h80);
    rd(2'd2, v); ss_i = 1'b1; repeat (3) @(negedge clk);
    ss_is_out = 1'b1; wr(2'd0, 8'h50); ss_i = 1'b0; repeat (4) @(negedge clk);
    rd(2'd0, v); chk(v == 8'h50, "R6 ss output ignored", v, 8'h50);
    rd(2'd1, v); chk(v == 8'h00, "R6 no flag", v, 0);
    ss_i = 1'b1; ss_is_out = 1'b0; repeat (3) @(negedge clk);

    // R10 slave sweep
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++) begin
        logic [7:0] bin, bout;
        bin = 8'h6B ^ {m[1:0], o[0], 5'b0}; bout = 8'h3A + 8'(m * 2 + o);
        b_cpol = m[1]; b_cpha = m[0];
        sck_i = b_cpol; ss_i = 1'b1;
        wr(2'd0, {1'b0, 1'b1, o[0], 1'b0, b_cpol, b_cpha, 2'b00});
        repeat (4) @(negedge clk);
        chk(miso_oe == 1'b0, "R10 tri-state", miso_oe, 0);
        if (m == 0) begin
          wr(2'd2, 8'hFF);
          ss_i = 1'b0; repeat (8) @(negedge clk);
          for (int i = 0; i < 3; i++) begin
            mosi_i = 1'b1; repeat (8) @(negedge clk);
            sck_i = 1'b1; repeat (8) @(negedge clk); sck_i = 1'b0;
          end
          repeat (8) @(negedge clk); ss_i = 1'b1; repeat (6) @(negedge clk);
        end
        wr(2'd2, bout);
        ss_i = 1'b0; repeat (8) @(negedge clk);
        chk(miso_oe == 1'b1, "R10 drive", miso_oe, 1);
        s = '0;
        for (int i = 0; i < 8; i++) begin
          if (!b_cpha) begin
            mosi_i = bin[o[0] ? i : 7 - i]; repeat (8) @(negedge clk);
            s = {s[6:0], miso_o}; sck_i = ~b_cpol; repeat (8) @(negedge clk);
            sck_i = b_cpol;
          end else begin
            sck_i = ~b_cpol; mosi_i = bin[o[0] ? i : 7 - i]; repeat (8) @(negedge clk);
            s = {s[6:0], miso_o}; sck_i = b_cpol; repeat (8) @(negedge clk);
          end
        end
        repeat (8) @(negedge clk); ss_i = 1'b1; repeat (4) @(negedge clk);
        chk(s == (o[0] ? rev8(bout) : bout), "R10 miso byte", s, o[0] ? rev8(bout) : bout);
        rd(2'd1, v); chk(v == 8'h80, "R10 flag", v, 8'h80);
        rd(2'd2, v); chk(v == bin, "R10 rx byte", v, bin);
      end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule